// File: doc/BRIEF.md
# Configurable shift slice

The block holds one 32-bit data word that streams to and from a group of pins. Each active event of a shift clock moves the word towards bit 0. The low bits go out on the pin outputs and fresh pin input bits enter at the top. A run-time width code sets the step to 1, 2, 4 or 8 bits per event.

The shift clock has two possible sources. One is an internal reloadable down-counter. The other is an external clock input, which is first synchronised into the system clock domain. A configuration bit picks the rising or the falling edge of the selected clock as the active event. A qualifier input gates the events, and its polarity can be inverted. The selected clock level is also driven out, with optional inversion. A bus write loads the data word directly and takes precedence over any shift in the same cycle.

A sticky interrupt flag is raised by a programmable condition on the captured input bit. When pattern matching is enabled, the flag is also raised when a shift produces a word equal to a reference value. Writing one to the clear input drops the flag.

Top module: `shift_slice`

## Requirements
- R1: When `wr_en` is 1 at a clock edge, `data_q` takes `wr_data` at that edge. No shift happens in that cycle and the interrupt flag is not set by it.
- R2: `data_q` changes only on a write or on a qualified shift event.
- R3: A shift with width code w (0, 1, 2, 3 meaning N = 1, 2, 4, 8 bits) sets `data_q` to the old word moved right by N. Bits `din[N-1:0]` enter bits 31 down to 32-N, with `din[N-1]` at bit 31.
- R4: `dout[N-1:0]` shows `data_q[N-1:0]` for the current width code, and `dout` bits at N and above are 0.
- R5: In internal mode (`cfg_ext_clk`=0) the counter starts at 0 after reset. It reloads `cnt_preset` each time it reaches 0, and the internal clock level toggles at each reload. Each level therefore lasts `cnt_preset`+1 cycles, and the level changes at the clock edge where the counter is 0.
- R6: `cfg_cap_fall`=0 makes a rising edge of the selected clock the active event, and `cfg_cap_fall`=1 makes a falling edge the active event. In internal mode the shift lands at the same clock edge as the level change.
- R7: In external mode (`cfg_ext_clk`=1), `ext_clk` passes through a two-flop synchroniser. The shift for an edge of `ext_clk` applied before clock edge k takes effect at clock edge k+2.
- R8: An active event shifts only when `qual` XOR `cfg_inv_qual` is 1.
- R9: `clk_out` is the selected clock level (the internal toggle, or the synchronised external clock) XOR `cfg_inv_clkout`.
- R10: On each shift the detector compares the captured bit `din[0]` with the previous captured bit, which resets to 0. `cfg_cond` codes are: 0 = rise (prev 0, bit 1), 1 = fall (prev 1, bit 0), 2 = bit is 0, 3 = bit is 1. A hit sets the flag.
- R11: With `cfg_match_en`=1, a shift whose result equals `match_ref` sets the flag. With `cfg_match_en`=0, the match has no effect.
- R12: `irq_flag` stays set until a cycle with `irq_clr`=1 clears it. A set event in that same cycle wins over the clear.
- R13: After reset, `data_q`, `irq_flag` and `clk_out` (with `cfg_inv_clkout`=0) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Bits per shift: 0=1, 1=2, 2=4, 3=8 |
| cfg_cap_fall | input | 1 | Active event is the falling edge of the shift clock |
| cfg_ext_clk | input | 1 | Use the external clock instead of the counter |
| cfg_inv_clkout | input | 1 | Invert the clock output |
| cfg_cond | input | 2 | Input-bit interrupt condition code |
| cfg_inv_qual | input | 1 | Invert the qualifier |
| cfg_match_en | input | 1 | Enable pattern matching |
| cnt_preset | input | CNT_W | Counter reload value |
| ext_clk | input | 1 | External shift clock |
| qual | input | 1 | Shift qualifier |
| din | input | PIN_W | Pin input bits |
| wr_en | input | 1 | Bus write strobe for the data word |
| wr_data | input | DATA_W | Bus write data |
| match_ref | input | DATA_W | Pattern compared after each shift |
| irq_clr | input | 1 | Write-one-to-clear for the flag |
| data_q | output | DATA_W | Data word |
| dout | output | PIN_W | Pin output bits |
| clk_out | output | 1 | Shift clock output |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The assertions assume that `qual`, `din`, the configuration inputs and the bus inputs are synchronous to `clk`. Only `ext_clk` may be asynchronous. The shift-content property further assumes that `din` is stable for the cycle it is sampled. The stimulus changes every input, `ext_clk` included, one nanosecond after a rising clock edge, so each input is held for a full cycle before it is sampled. The external clock is held for at least three cycles per level, so the synchroniser never misses an edge.

// File: rtl/slice_pkg.sv
package slice_pkg;

  typedef enum logic [1:0] {
    COND_RISE = 2'd0,
    COND_FALL = 2'd1,
    COND_LOW  = 2'd2,
    COND_HIGH = 2'd3
  } cond_e;

  // Number of bits moved per shift for a width code.
  function automatic int unsigned step_bits(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // Input-bit condition evaluated on a shift.
  function automatic logic cond_hit(input cond_e c, input logic prev, input logic cur);
    case (c)
      COND_RISE: return ~prev & cur;
      COND_FALL: return prev & ~cur;
      COND_LOW:  return ~cur;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/slice_clkgen.sv
module slice_clkgen #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic             cap_fall,
  input  logic             inv_out,
  input  logic [CNT_W-1:0] preset,
  input  logic             ext_clk,
  output logic             shift_edge,
  output logic             clk_out
);

  logic [CNT_W-1:0] cnt;
  logic             tgl;
  logic             s1, s2, s3;
  logic             tick;
  logic             rise_e, fall_e;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tgl <= 1'b0;
    end else if (tick) begin
      cnt <= preset;
      tgl <= ~tgl;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_clk;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb begin
    if (ext_sel) begin
      rise_e = s2 & ~s3;
      fall_e = ~s2 & s3;
    end else begin
      rise_e = tick & ~tgl;
      fall_e = tick & tgl;
    end
  end

  assign shift_edge = cap_fall ? fall_e : rise_e;
  assign clk_out    = (ext_sel ? s2 : tgl) ^ inv_out;

endmodule

// File: rtl/slice_shreg.sv
module slice_shreg #(
  parameter int DATA_W = 32,
  parameter int PIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              shift_en,
  input  logic [1:0]        width,
  input  logic [PIN_W-1:0]  din,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] data_nx,
  output logic [PIN_W-1:0]  dout
);
  import slice_pkg::*;

  int unsigned n;
  assign n = step_bits(width);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      int unsigned idx;
      idx = i + n;
      if (idx < DATA_W) data_nx[i] = data_q[idx];
      else if (idx - DATA_W < PIN_W) data_nx[i] = din[idx - DATA_W];
      else data_nx[i] = 1'b0;
    end
  end

  always_comb begin
    for (int j = 0; j < PIN_W; j++) begin
      dout[j] = (j < n) ? data_q[j] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (wr_en)    data_q <= wr_data;
    else if (shift_en) data_q <= data_nx;
  end

endmodule

// File: rtl/slice_irq.sv
module slice_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic [1:0] cond,
  input  logic       bit_in,
  input  logic       match_en,
  input  logic       match_hit,
  input  logic       clr,
  output logic       flag,
  output logic       set
);
  import slice_pkg::*;

  logic prev;

  assign set = shift_en & (cond_hit(cond_e'(cond), prev, bit_in) | (match_en & match_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (shift_en) prev <= bit_in;
      flag <= set | (flag & ~clr);
    end
  end

endmodule

// File: rtl/shift_slice.sv
module shift_slice #(
  parameter int DATA_W = 32,
  parameter int PIN_W  = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_cap_fall,
  input  logic              cfg_ext_clk,
  input  logic              cfg_inv_clkout,
  input  logic [1:0]        cfg_cond,
  input  logic              cfg_inv_qual,
  input  logic              cfg_match_en,
  input  logic [CNT_W-1:0]  cnt_preset,
  input  logic              ext_clk,
  input  logic              qual,
  input  logic [PIN_W-1:0]  din,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] match_ref,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] data_q,
  output logic [PIN_W-1:0]  dout,
  output logic              clk_out,
  output logic              irq_flag
);

  logic              shift_edge;
  logic              shift_en;
  logic              irq_set;
  logic              match_hit;
  logic [DATA_W-1:0] data_nx;

  slice_clkgen #(.CNT_W(CNT_W)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_sel    (cfg_ext_clk),
    .cap_fall   (cfg_cap_fall),
    .inv_out    (cfg_inv_clkout),
    .preset     (cnt_preset),
    .ext_clk    (ext_clk),
    .shift_edge (shift_edge),
    .clk_out    (clk_out)
  );

  assign shift_en = shift_edge & (qual ^ cfg_inv_qual) & ~wr_en;

  slice_shreg #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .shift_en (shift_en),
    .width    (cfg_width),
    .din      (din),
    .data_q   (data_q),
    .data_nx  (data_nx),
    .dout     (dout)
  );

  assign match_hit = (data_nx == match_ref);

  slice_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .cond      (cfg_cond),
    .bit_in    (din[0]),
    .match_en  (cfg_match_en),
    .match_hit (match_hit),
    .clr       (irq_clr),
    .flag      (irq_flag),
    .set       (irq_set)
  );

endmodule

// File: rtl/slice_chk.sv
module slice_chk #(
  parameter int DATA_W = 32,
  parameter int PIN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] data_q,
  input logic [PIN_W-1:0]  din,
  input logic [PIN_W-1:0]  dout,
  input logic [1:0]        cfg_width,
  input logic              shift_en,
  input logic              qual,
  input logic              cfg_inv_qual,
  input logic              irq_clr,
  input logic              irq_set,
  input logic              irq_flag
);

  a_r1_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> data_q == $past(wr_data));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !wr_en) |=> $stable(data_q));

  a_r3_single_bit_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && cfg_width == 2'd0) |=>
      data_q == {$past(din[0]), $past(data_q[DATA_W-1:1])});

  a_r4_dout_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_width == 2'd0) |-> dout[PIN_W-1:1] == '0);

  a_r8_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (qual != cfg_inv_qual));

  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !irq_flag);

  a_r12_set: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_flag);

endmodule

bind shift_slice slice_chk #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .data_q       (data_q),
  .din          (din),
  .dout         (dout),
  .cfg_width    (cfg_width),
  .shift_en     (shift_en),
  .qual         (qual),
  .cfg_inv_qual (cfg_inv_qual),
  .irq_clr      (irq_clr),
  .irq_set      (irq_set),
  .irq_flag     (irq_flag)
);

// File: tb/test_shift_slice.sv
`timescale 1ns/1ps
module test_shift_slice;
  localparam int DW = 32;
  localparam int PW = 8;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_width = '0, cfg_cond = '0;
  logic cfg_cap_fall = 0, cfg_ext_clk = 0, cfg_inv_clkout = 0, cfg_inv_qual = 0, cfg_match_en = 0;
  logic [CW-1:0] cnt_preset = '0;
  logic ext_clk = 0, qual = 0, wr_en = 0, irq_clr = 0;
  logic [PW-1:0] din = '0;
  logic [DW-1:0] wr_data = '0, match_ref = '0;
  logic [DW-1:0] data_q;
  logic [PW-1:0] dout;
  logic clk_out, irq_flag;

  always #2.5 clk = ~clk;

  shift_slice #(.DATA_W(DW), .PIN_W(PW), .CNT_W(CW)) i_shift_slice (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_cap_fall(cfg_cap_fall),
    .cfg_ext_clk(cfg_ext_clk), .cfg_inv_clkout(cfg_inv_clkout), .cfg_cond(cfg_cond),
    .cfg_inv_qual(cfg_inv_qual), .cfg_match_en(cfg_match_en), .cnt_preset(cnt_preset),
    .ext_clk(ext_clk), .qual(qual), .din(din), .wr_en(wr_en), .wr_data(wr_data),
    .match_ref(match_ref), .irq_clr(irq_clr), .data_q(data_q), .dout(dout),
    .clk_out(clk_out), .irq_flag(irq_flag)
  );

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R3";

  // Behavioural reference model
  int m_cnt = 0;
  bit m_lvl = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0, m_prev = 0, m_flag = 0;
  bit [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_lvl = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_prev = 0; m_flag = 0; m_data = '0;
    end else begin
      bit zero, up, down, ev, sh, hit;
      int n;
      bit [DW-1:0] nx;
      zero = (m_cnt == 0);
      if (cfg_ext_clk) begin up = m_s2 && !m_s3; down = !m_s2 && m_s3; end
      else begin up = zero && !m_lvl; down = zero && m_lvl; end
      ev = cfg_cap_fall ? down : up;
      sh = ev && (qual != cfg_inv_qual) && !wr_en;
      n = 1 << cfg_width;
      nx = m_data >> n;
      for (int k = 0; k < n; k++) nx[DW - n + k] = din[k];
      hit = 0;
      if (sh) begin
        case (cfg_cond)
          2'd0: hit = !m_prev && din[0];
          2'd1: hit = m_prev && !din[0];
          2'd2: hit = !din[0];
          default: hit = din[0];
        endcase
        if (cfg_match_en && nx == match_ref) hit = 1;
        m_prev = din[0];
      end
      m_flag = hit || (m_flag && !irq_clr);
      if (wr_en) m_data = wr_data;
      else if (sh) m_data = nx;
      if (zero) begin m_cnt = cnt_preset; m_lvl = !m_lvl; end
      else m_cnt = m_cnt - 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    bit [PW-1:0] md;
    for (int j = 0; j < PW; j++) md[j] = (j < (1 << cfg_width)) ? m_data[j] : 1'b0;
    chk(cur_req, "data_q", data_q, m_data);
    chk("R4", "dout", dout, md);
    chk("R9", "clk_out", clk_out, (cfg_ext_clk ? m_s2 : m_lvl) ^ cfg_inv_clkout);
    chk("R12", "irq_flag", irq_flag, m_flag);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int k = 1);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic write_word(input logic [DW-1:0] v);
    wr_en = 1; wr_data = v; step(); wr_en = 0;
  endtask

  // One external rising edge, shifted after the synchroniser, then the low half
  task automatic ext_pulse();
    ext_clk = 1; step(3); ext_clk = 0; step(3);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    // R13: reset state
    chk("R13", "reset data", data_q, 0);
    chk("R13", "reset flag", irq_flag, 0);

    // R1: bus load
    cur_req = "R1";
    cfg_ext_clk = 1; qual = 1;
    write_word(32'hA5A5_0F0F);
    chk("R1", "write", data_q, 32'hA5A5_0F0F);

    // R7: external clock latency, R3 8-bit step
    cur_req = "R7";
    cfg_width = 2'd3; din = 8'h3C;
    ext_clk = 1; step(2);
    chk("R7", "no shift yet", data_q, 32'hA5A5_0F0F);
    step();
    chk("R7", "shifted", data_q, 32'h3CA5_A50F);
    ext_clk = 0; step(3);
    chk("R6", "falling edge ignored", data_q, 32'h3CA5_A50F);

    // R6: falling edge capture
    cfg_cap_fall = 1; cfg_width = 2'd2; din = 8'h0B;
    ext_pulse();
    chk("R6", "fall capture", data_q, 32'hB3CA_5A50);
    cfg_cap_fall = 0;

    // R8: qualifier gating and inversion
    cur_req = "R8";
    qual = 0; ext_pulse();
    chk("R8", "qual low blocks", data_q, 32'hB3CA_5A50);
    cfg_inv_qual = 1; cfg_width = 2'd1; din = 8'h02;
    ext_pulse();
    chk("R8", "inverted qual shifts", data_q, 32'hACF2_9694);
    cfg_inv_qual = 0; qual = 1;

    // R1: write wins over a shift in the same cycle
    cur_req = "R1";
    ext_clk = 1; step(2); wr_en = 1; wr_data = 32'h1234_5678; step(); wr_en = 0;
    chk("R1", "write over shift", data_q, 32'h1234_5678);
    ext_clk = 0; step(3);

    // R11: match mode
    cur_req = "R11";
    cfg_cond = 2'd0; cfg_width = 2'd3; din = 8'h44;
    match_ref = 32'h4400_1122; cfg_match_en = 1;
    irq_clr = 1; step(); irq_clr = 0;
    write_word(32'h0011_2233);
    ext_pulse();
    chk("R11", "match sets flag", irq_flag, 1);
    irq_clr = 1; step(); irq_clr = 0;
    chk("R12", "cleared", irq_flag, 0);
    cfg_match_en = 0;
    write_word(32'h0011_2233);
    ext_pulse();
    chk("R11", "match disabled", irq_flag, 0);

    // R10: condition codes
    cur_req = "R10";
    cfg_width = 2'd0;
    cfg_cond = 2'd3; din = 8'h01; ext_pulse();
    chk("R10", "high level", irq_flag, 1);
    irq_clr = 1; step(); irq_clr = 0;
    cfg_cond = 2'd2; ext_pulse();
    chk("R10", "low not hit", irq_flag, 0);
    cfg_cond = 2'd1; din = 8'h00; ext_pulse();
    chk("R10", "fall hit", irq_flag, 1);
    // R12: set wins over clear
    cfg_cond = 2'd2;
    ext_clk = 1; step(2); irq_clr = 1; step(); irq_clr = 0;
    chk("R12", "set beats clear", irq_flag, 1);
    ext_clk = 0; step(3);
    irq_clr = 1; step(); irq_clr = 0;
    cfg_cond = 2'd0; din = 8'h01; ext_pulse();
    chk("R10", "rise hit", irq_flag, 1);

    // R5, R6, R9: internal clock runs against the model for every width and edge
    cur_req = "R5";
    cfg_ext_clk = 0;
    for (int w = 0; w < 4; w++) begin
      for (int f = 0; f < 2; f++) begin
        cfg_width = w[1:0]; cfg_cap_fall = f[0]; cfg_inv_clkout = w[0];
        cnt_preset = CW'(w + 1); cfg_cond = w[1:0];
        for (int c = 0; c < 60; c++) begin
          din = PW'($urandom);
          qual = ($urandom % 4) != 0;
          irq_clr = ($urandom % 8) == 0;
          step();
        end
        irq_clr = 0;
      end
    end

    // R9: level check with inversion, preset 0 toggles every cycle
    cfg_inv_clkout = 1; cnt_preset = '0; step(2);
    begin
      logic a;
      a = clk_out; step();
      chk("R9", "toggle", clk_out, !a);
    end

    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule